// File: doc/BRIEF.md
# Multi-Port Banked Scratchpad

This block is an on-chip scratchpad shared by several access ports. Its storage is split into independent banks, so accesses that land in different banks all finish in the same cycle. A compile-time mask says which address bits pick the bank. The default mask uses the lowest address bits, which places consecutive words in different banks. The remaining address bits, kept in their original order, form the row address inside the bank.

Each bank has one write path and one read path, and both can be used in the same cycle. Every bank has two round-robin arbiters, one for readers and one for writers. When more than one port of the same kind hits the same bank, the arbiter grants one port per cycle. The other ports see `ready` low and hold their request until they are granted. A granted read returns its data one cycle later, together with a per-port valid flag.

Each port is a valid/ready channel. A request completes in the cycle where `req` and `ready` are both high. The block has no state machine: its only sequential state is a rotating priority pointer in each arbiter, the bank arrays, and one read-return register per port.

Top module: `banked_scratchpad`

## Requirements
- R1: The bank index is built from the address bits set in `BANK_MASK`, with the lowest set bit giving bank-index bit 0. The row is built from the unmasked address bits, kept in order. The default mask 0x3 takes the bank from addr[1:0]; mask 0x180 takes it from addr[8:7].
- R2: When every requesting port targets a different bank, every port gets `ready` in that same cycle.
- R3: In any cycle, each bank grants at most one read and at most one write. A read and a write to the same bank are both granted in the same cycle.
- R4: Same-kind requests to one bank are served round-robin, one per cycle. A batch of k such held requests completes in exactly k cycles, and no port waits NPORTS cycles or more.
- R5: `ready` is high only for ports with `req` high. A port with `req` low (write enable 1) changes no memory content and produces no `rvalid`.
- R6: `rvalid[p]` is high exactly one cycle after a cycle in which port p had a read granted, and is low at all other times.
- R7: A read and a write to the same address granted in the same cycle return the old content to the reader.
- R8: A granted read returns the value of the last granted write to that address.
- R9: During and after reset, `ready` and `rvalid` are low while no request is present. Every arbiter restarts with port 0 as highest priority. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORTS | Per-port access request |
| we | input | NPORTS | Per-port write enable (1 = write, 0 = read) |
| addr | input | NPORTS x ADDR_W | Per-port word address |
| wdata | input | NPORTS x DATA_W | Per-port write data |
| ready | output | NPORTS | Request granted this cycle |
| rvalid | output | NPORTS | Read data valid (one cycle after a read grant) |
| rdata | output | NPORTS x DATA_W | Per-port read data |

## Verification
The bench uses two instances, one with the low-bit mask and one with mask 0x180. It runs batches that are conflict-free and batches where every port hits one bank. Each batch must finish in exactly the expected number of cycles, which separates parallel service from serialization. Mixed batches put one read and one write into the same bank at once, and one such batch uses a single address, which shows that the read and write paths are independent and that the reader gets the old data. The same address set is sent to both instances. It is conflict-free on one and fully conflicting on the other, so each cycle count shows which bits the bank index really uses. Every read result is compared with a flat reference array.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;

    // Gathers the bits of value selected by mask into the low end of the
    // result, keeping their order (lowest selected bit lands in bit 0).
    function automatic logic [31:0] sel_bits(input logic [31:0] value,
                                             input logic [31:0] mask);
        logic [31:0] r;
        int          k;
        r = '0;
        k = 0;
        for (int i = 0; i < 32; i++) begin
            if (mask[i]) begin
                r[k] = value[i];
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sp_rr_arbiter.sv
module sp_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic          hit;

    // Search starts at ptr and wraps; first requester found wins.
    always_comb begin
        int idx;
        gnt = '0;
        win = '0;
        hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!hit && req[idx]) begin
                hit      = 1'b1;
                gnt[idx] = 1'b1;
                win      = IW'(idx);
            end
        end
    end

    // Winner drops to lowest priority on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (hit) begin
            ptr <= (int'(win) == N - 1) ? '0 : IW'(int'(win) + 1);
        end
    end

endmodule

// File: rtl/sp_bank_ram.sv
module sp_bank_ram #(
    parameter int DW   = 32,
    parameter int ROWS = 128,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [RW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [ROWS];

    // Nonblocking update: a same-cycle read sees the old word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
    import sp_bank_pkg::*;
#(
    parameter int          NPORTS    = 4,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 9,
    parameter int          NBANKS    = 4,
    parameter logic [31:0] BANK_MASK = 32'h0000_0003
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORTS-1:0]             req,
    input  logic [NPORTS-1:0]             we,
    input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
    input  logic [NPORTS-1:0][DATA_W-1:0] wdata,
    output logic [NPORTS-1:0]             ready,
    output logic [NPORTS-1:0]             rvalid,
    output logic [NPORTS-1:0][DATA_W-1:0] rdata
);
    localparam int          BW    = $clog2(NBANKS);
    localparam int          RW    = ADDR_W - BW;
    localparam int          ROWS  = 1 << RW;
    localparam logic [31:0] AMASK = 32'((64'd1 << ADDR_W) - 64'd1);
    localparam logic [31:0] RMASK = AMASK & ~BANK_MASK;

    logic [BW-1:0]     port_bank [NPORTS];
    logic [RW-1:0]     port_row  [NPORTS];
    logic [NPORTS-1:0] rd_gnt    [NBANKS];
    logic [NPORTS-1:0] wr_gnt    [NBANKS];
    logic [DATA_W-1:0] bank_q    [NBANKS];
    logic [NPORTS-1:0] rd_any;
    logic [BW-1:0]     sel_q     [NPORTS];

    // Address split: masked bits -> bank, the rest in order -> row.
    always_comb begin
        logic [31:0] bsel;
        logic [31:0] rsel;
        for (int p = 0; p < NPORTS; p++) begin
            bsel         = sel_bits(32'(addr[p]), BANK_MASK);
            rsel         = sel_bits(32'(addr[p]), RMASK);
            port_bank[p] = bsel[BW-1:0];
            port_row[p]  = rsel[RW-1:0];
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [NPORTS-1:0] rq_r, rq_w, g_r, g_w;
        logic [RW-1:0]     wa, ra;
        logic [DATA_W-1:0] wd;

        always_comb begin
            for (int p = 0; p < NPORTS; p++) begin
                rq_r[p] = req[p] & ~we[p] & (port_bank[p] == BW'(b));
                rq_w[p] = req[p] &  we[p] & (port_bank[p] == BW'(b));
            end
        end

        sp_rr_arbiter #(.N(NPORTS)) u_rd_arb (
            .clk(clk), .rst_n(rst_n), .req(rq_r), .gnt(g_r)
        );
        sp_rr_arbiter #(.N(NPORTS)) u_wr_arb (
            .clk(clk), .rst_n(rst_n), .req(rq_w), .gnt(g_w)
        );

        always_comb begin
            wa = '0;
            ra = '0;
            wd = '0;
            for (int p = 0; p < NPORTS; p++) begin
                if (g_w[p]) begin
                    wa = port_row[p];
                    wd = wdata[p];
                end
                if (g_r[p]) ra = port_row[p];
            end
        end

        sp_bank_ram #(.DW(DATA_W), .ROWS(ROWS)) u_ram (
            .clk(clk), .we(|g_w), .waddr(wa), .wdata(wd),
            .re(|g_r), .raddr(ra), .rdata(bank_q[b])
        );

        assign rd_gnt[b] = g_r;
        assign wr_gnt[b] = g_w;
    end

    always_comb begin
        ready  = '0;
        rd_any = '0;
        for (int b = 0; b < NBANKS; b++) begin
            ready  = ready | rd_gnt[b] | wr_gnt[b];
            rd_any = rd_any | rd_gnt[b];
        end
    end

    // Remember which bank each granted read went to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= '0;
            for (int p = 0; p < NPORTS; p++) sel_q[p] <= '0;
        end else begin
            rvalid <= rd_any;
            for (int p = 0; p < NPORTS; p++) begin
                if (rd_any[p]) sel_q[p] <= port_bank[p];
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPORTS; p++) rdata[p] = bank_q[sel_q[p]];
    end

endmodule

// File: rtl/banked_scratchpad_chk.sv
module banked_scratchpad_chk
    import sp_bank_pkg::*;
#(
    parameter int          NPORTS    = 4,
    parameter int          ADDR_W    = 9,
    parameter int          NBANKS    = 4,
    parameter logic [31:0] BANK_MASK = 32'h0000_0003
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NPORTS-1:0]             req,
    input logic [NPORTS-1:0]             we,
    input logic [NPORTS-1:0][ADDR_W-1:0] addr,
    input logic [NPORTS-1:0]             ready,
    input logic [NPORTS-1:0]             rvalid
);
    localparam int BW = $clog2(NBANKS);

    logic              armed;
    logic [BW-1:0]     pbank  [NPORTS];
    logic [NPORTS-1:0] lone;
    int                rd_cnt [NBANKS];
    int                wr_cnt [NBANKS];
    int                wcnt   [NPORTS];

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        logic [31:0] t;
        for (int p = 0; p < NPORTS; p++) begin
            t        = sel_bits(32'(addr[p]), BANK_MASK);
            pbank[p] = t[BW-1:0];
        end
        for (int b = 0; b < NBANKS; b++) begin
            rd_cnt[b] = 0;
            wr_cnt[b] = 0;
            for (int p = 0; p < NPORTS; p++) begin
                if (ready[p] && req[p] && int'(pbank[p]) == b) begin
                    if (we[p]) wr_cnt[b]++;
                    else       rd_cnt[b]++;
                end
            end
        end
        for (int p = 0; p < NPORTS; p++) begin
            lone[p] = req[p];
            for (int q = 0; q < NPORTS; q++) begin
                if (q != p && req[q] && we[q] == we[p] && pbank[q] == pbank[p])
                    lone[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            if (!rst_n)                    wcnt[p] <= 0;
            else if (req[p] && !ready[p])  wcnt[p] <= wcnt[p] + 1;
            else                           wcnt[p] <= 0;
        end
    end

    assert_ready_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready & ~req) == '0)
        else $error("ready without request");

    assert_rvalid_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (rvalid == $past(ready & req & ~we)))
        else $error("rvalid not aligned to read grant");

    for (genvar b = 0; b < NBANKS; b++) begin : g_bchk
        assert_one_read_per_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_cnt[b] <= 1)
            else $error("two reads granted in one bank");
        assert_one_write_per_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_cnt[b] <= 1)
            else $error("two writes granted in one bank");
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_pchk
        assert_lone_request_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
            lone[p] |-> ready[p])
            else $error("uncontended request stalled");
        assert_wait_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wcnt[p] < NPORTS)
            else $error("port starved");
    end

endmodule

bind banked_scratchpad banked_scratchpad_chk #(
    .NPORTS(NPORTS), .ADDR_W(ADDR_W), .NBANKS(NBANKS), .BANK_MASK(BANK_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .ready(ready), .rvalid(rvalid)
);

// File: tb/banked_scratchpad_bench.sv
module banked_scratchpad_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]       b_req [2];
    logic [3:0]       b_we  [2];
    logic [3:0]       b_rdy [2];
    logic [3:0]       b_rv  [2];
    logic [3:0][8:0]  b_ad  [2];
    logic [3:0][31:0] b_wd  [2];
    logic [3:0][31:0] b_rd  [2];

    logic [31:0] ref_mem [2][512];
    int   n_chk = 0;
    int   n_fail = 0;
    int   serial = 0;
    bit   done = 1'b0;
    logic [3:0] first_rdy;

    banked_scratchpad u_banked_scratchpad (
        .clk(clk), .rst_n(rst_n), .req(b_req[0]), .we(b_we[0]), .addr(b_ad[0]),
        .wdata(b_wd[0]), .ready(b_rdy[0]), .rvalid(b_rv[0]), .rdata(b_rd[0])
    );

    banked_scratchpad #(.BANK_MASK(32'h0000_0180)) u_banked_scratchpad_hi (
        .clk(clk), .rst_n(rst_n), .req(b_req[1]), .we(b_we[1]), .addr(b_ad[1]),
        .wdata(b_wd[1]), .ready(b_rdy[1]), .rvalid(b_rv[1]), .rdata(b_rd[1])
    );

    // Table: request mask, write mask, addresses {p3,p2,p1,p0}, expected cycles.
    localparam int NV = 11;
    localparam logic [3:0] V_REQ [NV] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
                                          4'hF, 4'hF, 4'hF, 4'hA, 4'hF};
    localparam logic [3:0] V_WE  [NV] = '{4'hF, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0,
                                          4'h5, 4'h4, 4'h0, 4'hA, 4'hC};
    localparam logic [3:0][8:0] V_AD [NV] = '{
        {9'd3,   9'd2,   9'd1,   9'd0},
        {9'd7,   9'd6,   9'd5,   9'd4},
        {9'd3,   9'd2,   9'd1,   9'd0},
        {9'd0,   9'd1,   9'd2,   9'd3},
        {9'd20,  9'd16,  9'd12,  9'd8},
        {9'd20,  9'd16,  9'd12,  9'd8},
        {9'd5,   9'd17,  9'd1,   9'd9},
        {9'd2,   9'd2,   9'd17,  9'd9},
        {9'd17,  9'd1,   9'd4,   9'd2},
        {9'd101, 9'd0,   9'd100, 9'd0},
        {9'd103, 9'd102, 9'd101, 9'd100}};
    localparam int V_CYC [NV] = '{1, 1, 1, 1, 4, 4, 2, 2, 2, 1, 1};

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_batch(input int d, input logic [3:0] rq, input logic [3:0] wm,
                             input logic [3:0][8:0] ad, input int exp_cyc,
                             input string tag);
        logic [3:0]  pend, rd, rexp;
        logic [31:0] expd [4];
        int          nr [4];
        int          nw [4];
        int          cyc;
        logic [1:0]  bk;
        pend = rq;
        cyc  = 0;
        while (pend != 4'h0 && cyc < 16) begin
            @(negedge clk);
            b_req[d] = pend;
            b_we[d]  = wm;
            b_ad[d]  = ad;
            for (int p = 0; p < 4; p++) b_wd[d][p] = 32'hC0DE_0000 ^ 32'(serial * 8 + p);
            #1;
            rd = b_rdy[d];
            if (cyc == 0) first_rdy = rd;
            chk((rd & ~pend) == 4'h0, "R5", {tag, " ready without request"}, 32'(rd), 32'(pend));
            chk(rd != 4'h0, "R4", {tag, " no progress"}, 32'(rd), 32'(pend));
            rexp = 4'h0;
            for (int b = 0; b < 4; b++) begin nr[b] = 0; nw[b] = 0; end
            for (int p = 0; p < 4; p++) begin
                expd[p] = '0;
                if (rd[p]) begin
                    bk = (d == 0) ? ad[p][1:0] : ad[p][8:7];
                    if (wm[p]) nw[bk]++;
                    else begin
                        nr[bk]++;
                        rexp[p] = 1'b1;
                        expd[p] = ref_mem[d][ad[p]];
                    end
                end
            end
            for (int b = 0; b < 4; b++)
                chk(nr[b] <= 1 && nw[b] <= 1, "R3", {tag, " grants per bank"},
                    32'(nr[b] * 16 + nw[b]), 32'h11);
            @(posedge clk);
            #1;
            chk(b_rv[d] == rexp, "R6", {tag, " rvalid"}, 32'(b_rv[d]), 32'(rexp));
            for (int p = 0; p < 4; p++)
                if (rexp[p]) chk(b_rd[d][p] == expd[p], "R8", {tag, " read data"},
                                 b_rd[d][p], expd[p]);
            for (int p = 0; p < 4; p++)
                if (rd[p] && wm[p]) ref_mem[d][ad[p]] = b_wd[d][p];
            pend = pend & ~rd;
            cyc++;
        end
        serial++;
        @(negedge clk);
        b_req[d] = 4'h0;
        chk(cyc == exp_cyc, (exp_cyc == 1) ? "R2" : "R4", {tag, " cycles"},
            32'(cyc), 32'(exp_cyc));
        @(posedge clk);
        #1;
        chk(b_rv[d] == 4'h0, "R6", {tag, " rvalid idle"}, 32'(b_rv[d]), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            b_req[d] = '0; b_we[d] = '0; b_ad[d] = '0; b_wd[d] = '0;
            for (int a = 0; a < 512; a++) ref_mem[d][a] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(b_rdy[d] == 4'h0, "R9", "ready in reset", 32'(b_rdy[d]), 32'h0);
            chk(b_rv[d] == 4'h0, "R9", "rvalid in reset", 32'(b_rv[d]), 32'h0);
        end
        rst_n = 1'b1;

        // Table walk on the low-bit-banked instance (R2, R3, R4, R7, R8).
        for (int v = 0; v < NV; v++)
            run_batch(0, V_REQ[v], V_WE[v], V_AD[v], V_CYC[v], $sformatf("vec%0d", v));

        // R1: bank bits 8:7. Consecutive words share a bank there.
        run_batch(1, 4'hF, 4'hF, {9'd3, 9'd2, 9'd1, 9'd0}, 4, "R1 hi consecutive wr");
        run_batch(1, 4'hF, 4'h0, {9'd0, 9'd1, 9'd2, 9'd3}, 4, "R1 hi consecutive rd");
        run_batch(1, 4'hF, 4'hF, {9'd384, 9'd256, 9'd128, 9'd0}, 1, "R1 hi strided wr");
        run_batch(1, 4'hF, 4'h0, {9'd0, 9'd128, 9'd256, 9'd384}, 1, "R1 hi strided rd");
        // R1: the same stride conflicts completely with low-bit banking.
        run_batch(0, 4'hF, 4'hF, {9'd0, 9'd384, 9'd256, 9'd128}, 4, "R1 lo strided wr");
        run_batch(0, 4'hF, 4'h0, {9'd128, 9'd256, 9'd384, 9'd0}, 4, "R1 lo strided rd");

        // R5: write enable without request is ignored.
        @(negedge clk);
        b_req[0] = 4'h0; b_we[0] = 4'hF;
        b_ad[0] = {9'd5, 9'd5, 9'd5, 9'd5};
        b_wd[0] = {4{32'hDEAD_BEEF}};
        #1;
        chk(b_rdy[0] == 4'h0, "R5", "ready with req low", 32'(b_rdy[0]), 32'h0);
        @(posedge clk);
        #1;
        chk(b_rv[0] == 4'h0, "R5", "rvalid with req low", 32'(b_rv[0]), 32'h0);
        run_batch(0, 4'h1, 4'h0, {9'd0, 9'd0, 9'd0, 9'd5}, 1, "R5 readback");

        // R9: reset in mid-run restarts the arbiters at port 0.
        run_batch(0, 4'h6, 4'h6, {9'd0, 9'd28, 9'd24, 9'd0}, 2, "R9 pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(b_rdy[0] == 4'h0, "R9", "ready in reset", 32'(b_rdy[0]), 32'h0);
        @(posedge clk);
        #1;
        chk(b_rv[0] == 4'h0, "R9", "rvalid in reset", 32'(b_rv[0]), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        run_batch(0, 4'hF, 4'hF, {9'd20, 9'd16, 9'd12, 9'd8}, 4, "R9 restart");
        chk(first_rdy == 4'h1, "R9", "first grant after reset", 32'(first_rdy), 32'h1);
        run_batch(0, 4'hF, 4'h0, {9'd8, 9'd12, 9'd16, 9'd20}, 4, "R9 contents kept");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule